// File: doc/BRIEF.md
# Power-management command port and reset control register

This block sits in a chipset's power-management register space and handles two byte-wide control functions. The first is a command port. Software writes a command byte to it. Two reserved command values switch the platform's ACPI mode on or off: each produces a one-cycle strobe towards the ACPI register block. Every other value is a request for system-management service. It raises a one-cycle SMI request, but only when the command-trigger enable bit of the SMI enable register is set.

The SMI enable register and a power-management configuration byte are stored in the block. The configuration byte holds a sticky lock bit. Once software sets this bit, it cannot clear it again, and the lowest bit of the SMI enable register is frozen at its current value. Only the power-on reset input releases the lock.

The second function is a reset control register. A write with the go bit set sends a one-cycle system reset request and leaves the stored byte unchanged. Any other write keeps only the full-reset and system-reset configuration bits. All registers use one write port with a two-bit register select. Reads are combinational from the same select.

Top module: `pmc_apm_rstctl`

## Requirements
- R1: After the power-on reset (`rst_ni` low), all four register selects read 0x00 and the four pulse outputs are low.
- R2: A write of the ACPI-on command (default 0xF1) to select 0 (command port) pulses `acpi_on_o` high for exactly the cycle after the write, and no SMI request is raised. Select 0 always reads 0x00.
- R3: A write of the ACPI-off command (default 0xF0) to select 0 pulses `acpi_off_o` high for the cycle after the write, and no SMI request is raised.
- R4: A write of any other value to select 0 pulses `smi_req_o` for the cycle after the write when bit 5 of the SMI enable register is 1. When that bit is 0, no pulse is produced.
- R5: While unlocked, select 1 (SMI enable) stores the full written byte and reads it back.
- R6: Select 2 (PM configuration) stores the written byte. Its bit 4 is the lock: once it reads 1, writes cannot clear it, and the other bits stay writable.
- R7: While the lock is 1, bit 0 of the SMI enable register keeps its value across writes, and bits 7..1 are still written.
- R8: A write to select 3 (reset control) with bit 2 clear stores the written byte ANDed with 0x0A, which keeps bits 3 and 1. Reads return the stored byte.
- R9: A write to select 3 with bit 2 set pulses `sys_rst_req_o` for the cycle after the write and leaves the stored byte unchanged.
- R10: Only `rst_ni` clears the lock and the registers. A system reset request leaves the lock set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 2 | Register select: 0 command, 1 SMI enable, 2 PM configuration, 3 reset control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| acpi_on_o | output | 1 | One-cycle ACPI-enable strobe |
| acpi_off_o | output | 1 | One-cycle ACPI-disable strobe |
| smi_req_o | output | 1 | One-cycle SMI request |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A wrong SMI enable value, or a wrong lock state, shows at the ports in two ways. It is visible on the read port as soon as the select is driven. It also shows in the cycle after the next command write, as a missing or spurious `smi_req_o`. A lock that fails to stick shows on the next write to select 2, or on a write to select 1 that changes bit 0. A corrupted reset control byte is visible on a read of select 3 directly after a go write, so every go write is followed by a read-back.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    SEL_CMD   = 2'd0,
    SEL_SMI   = 2'd1,
    SEL_CFG   = 2'd2,
    SEL_RST   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pmc_apm_decode.sv
module pmc_apm_decode #(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  ACPI_ON  = 8'hF1,
  parameter logic [7:0]  ACPI_OFF = 8'hF0,
  parameter int          TRIG_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_wr_i,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic [DATA_W-1:0] smi_en_i,
  output logic              acpi_on_o,
  output logic              acpi_off_o,
  output logic              smi_o
);
  logic hit_on, hit_off, hit_smi;

  always_comb begin
    hit_on  = cmd_wr_i && (cmd_i == DATA_W'(ACPI_ON));
    hit_off = cmd_wr_i && (cmd_i == DATA_W'(ACPI_OFF));
    // mode commands never trigger SMI
    hit_smi = cmd_wr_i && !hit_on && !hit_off && smi_en_i[TRIG_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acpi_on_o  <= 1'b0;
      acpi_off_o <= 1'b0;
      smi_o      <= 1'b0;
    end else begin
      acpi_on_o  <= hit_on;
      acpi_off_o <= hit_off;
      smi_o      <= hit_smi;
    end
  end
endmodule

// File: rtl/pmc_smi_regs.sv
module pmc_smi_regs #(
  parameter int          DATA_W      = 8,
  parameter int          LOCK_BIT    = 4,
  parameter logic [7:0]  LOCKED_MASK = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smi_wr_i,
  input  logic              cfg_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] smi_en_o,
  output logic [DATA_W-1:0] cfg_o,
  output logic              lock_o
);
  logic [DATA_W-1:0] smi_q, smi_d;
  logic [DATA_W-1:0] cfg_q, cfg_d;

  for (genvar i = 0; i < DATA_W; i++) begin : g_smi_bit
    if (LOCKED_MASK[i]) begin : g_lockable
      assign smi_d[i] = (smi_wr_i && !cfg_q[LOCK_BIT]) ? wdata_i[i] : smi_q[i];
    end else begin : g_free
      assign smi_d[i] = smi_wr_i ? wdata_i[i] : smi_q[i];
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_cfg_bit
    if (i == LOCK_BIT) begin : g_sticky
      assign cfg_d[i] = cfg_wr_i ? (cfg_q[i] | wdata_i[i]) : cfg_q[i];
    end else begin : g_plain
      assign cfg_d[i] = cfg_wr_i ? wdata_i[i] : cfg_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_q <= '0;
      cfg_q <= '0;
    end else begin
      smi_q <= smi_d;
      cfg_q <= cfg_d;
    end
  end

  assign smi_en_o = smi_q;
  assign cfg_o    = cfg_q;
  assign lock_o   = cfg_q[LOCK_BIT];
endmodule

// File: rtl/pmc_rst_ctl.sv
module pmc_rst_ctl #(
  parameter int          DATA_W    = 8,
  parameter int          GO_BIT    = 2,
  parameter logic [7:0]  KEEP_MASK = 8'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] val_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] val_q;
  logic              go;

  assign go = wr_i && wdata_i[GO_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q     <= '0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= go;
      if (wr_i && !go) val_q <= wdata_i & DATA_W'(KEEP_MASK);
    end
  end

  assign val_o = val_q;
endmodule

// File: rtl/pmc_apm_rstctl.sv
module pmc_apm_rstctl #(
  parameter int          DATA_W      = 8,
  parameter logic [7:0]  ACPI_ON     = 8'hF1,
  parameter logic [7:0]  ACPI_OFF    = 8'hF0,
  parameter int          TRIG_BIT    = 5,
  parameter int          LOCK_BIT    = 4,
  parameter logic [7:0]  LOCKED_MASK = 8'h01,
  parameter int          GO_BIT      = 2,
  parameter logic [7:0]  KEEP_MASK   = 8'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              acpi_on_o,
  output logic              acpi_off_o,
  output logic              smi_req_o,
  output logic              sys_rst_req_o
);
  import pmc_pkg::*;

  logic              wr_cmd, wr_smi, wr_cfg, wr_rst;
  logic [DATA_W-1:0] smi_en_q, cfg_q, rst_val_q;
  logic              lock_q;

  assign wr_cmd = wr_en_i && (addr_i == SEL_CMD);
  assign wr_smi = wr_en_i && (addr_i == SEL_SMI);
  assign wr_cfg = wr_en_i && (addr_i == SEL_CFG);
  assign wr_rst = wr_en_i && (addr_i == SEL_RST);

  pmc_apm_decode #(
    .DATA_W(DATA_W), .ACPI_ON(ACPI_ON), .ACPI_OFF(ACPI_OFF), .TRIG_BIT(TRIG_BIT)
  ) u_decode (
    .clk_i, .rst_ni,
    .cmd_wr_i  (wr_cmd),
    .cmd_i     (wdata_i),
    .smi_en_i  (smi_en_q),
    .acpi_on_o (acpi_on_o),
    .acpi_off_o(acpi_off_o),
    .smi_o     (smi_req_o)
  );

  pmc_smi_regs #(
    .DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT), .LOCKED_MASK(LOCKED_MASK)
  ) u_smi (
    .clk_i, .rst_ni,
    .smi_wr_i(wr_smi),
    .cfg_wr_i(wr_cfg),
    .wdata_i (wdata_i),
    .smi_en_o(smi_en_q),
    .cfg_o   (cfg_q),
    .lock_o  (lock_q)
  );

  pmc_rst_ctl #(
    .DATA_W(DATA_W), .GO_BIT(GO_BIT), .KEEP_MASK(KEEP_MASK)
  ) u_rst (
    .clk_i, .rst_ni,
    .wr_i     (wr_rst),
    .wdata_i  (wdata_i),
    .val_o    (rst_val_q),
    .rst_req_o(sys_rst_req_o)
  );

  always_comb begin
    unique case (addr_i)
      SEL_SMI: rdata_o = smi_en_q;
      SEL_CFG: rdata_o = cfg_q;
      SEL_RST: rdata_o = rst_val_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pmc_apm_rstctl_chk.sv
module pmc_apm_rstctl_chk #(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  ACPI_ON  = 8'hF1,
  parameter logic [7:0]  ACPI_OFF = 8'hF0,
  parameter int          TRIG_BIT = 5,
  parameter int          GO_BIT   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              acpi_on_o,
  input logic              acpi_off_o,
  input logic              smi_req_o,
  input logic              sys_rst_req_o,
  input logic [DATA_W-1:0] smi_en_q,
  input logic              lock_q,
  input logic [DATA_W-1:0] rst_val_q
);
  logic cmd_wr, rst_wr;
  assign cmd_wr = wr_en_i && (addr_i == 2'd0);
  assign rst_wr = wr_en_i && (addr_i == 2'd3);

  // R2
  acpi_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i == DATA_W'(ACPI_ON)) |=> (acpi_on_o && !smi_req_o));
  // R3
  acpi_off_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i == DATA_W'(ACPI_OFF)) |=> (acpi_off_o && !smi_req_o));
  // R4
  smi_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i != DATA_W'(ACPI_ON) && wdata_i != DATA_W'(ACPI_OFF)
     && smi_en_q[TRIG_BIT]) |=> smi_req_o);
  // R4
  smi_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !smi_en_q[TRIG_BIT]) |=> !smi_req_o);
  // R6
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  // R7
  locked_bit0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(smi_en_q[0]));
  // R9
  rst_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_wr && wdata_i[GO_BIT]) |=> (sys_rst_req_o && $stable(rst_val_q)));
endmodule

bind pmc_apm_rstctl pmc_apm_rstctl_chk #(
  .DATA_W(DATA_W), .ACPI_ON(ACPI_ON), .ACPI_OFF(ACPI_OFF),
  .TRIG_BIT(TRIG_BIT), .GO_BIT(GO_BIT)
) chk_i (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
  .acpi_on_o, .acpi_off_o, .smi_req_o, .sys_rst_req_o,
  .smi_en_q, .lock_q, .rst_val_q
);

// File: tb/pmc_apm_rstctl_tb.sv
module pmc_apm_rstctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       acpi_on, acpi_off, smi_req, rst_req;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  pmc_apm_rstctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .acpi_on_o(acpi_on), .acpi_off_o(acpi_off),
    .smi_req_o(smi_req), .sys_rst_req_o(rst_req)
  );

  // {req[3:0], sel[1:0], wdata[7:0], flags{on,off,smi,rst}[3:0], read-back[7:0]}
  localparam int NV = 17;
  localparam logic [25:0] VECS [NV] = '{
    {4'd5,  2'd1, 8'h21, 4'b0000, 8'h21}, // R5 enable trigger + bit0
    {4'd2,  2'd0, 8'hF1, 4'b1000, 8'h00}, // R2 ACPI on, no SMI
    {4'd3,  2'd0, 8'hF0, 4'b0100, 8'h00}, // R3 ACPI off, no SMI
    {4'd4,  2'd0, 8'h42, 4'b0010, 8'h00}, // R4 SMI raised
    {4'd5,  2'd1, 8'h01, 4'b0000, 8'h01}, // R5
    {4'd4,  2'd0, 8'h42, 4'b0000, 8'h00}, // R4 trigger disabled
    {4'd5,  2'd1, 8'h21, 4'b0000, 8'h21}, // R5
    {4'd6,  2'd2, 8'h13, 4'b0000, 8'h13}, // R6 set lock
    {4'd6,  2'd2, 8'h02, 4'b0000, 8'h12}, // R6 lock sticks
    {4'd7,  2'd1, 8'h20, 4'b0000, 8'h21}, // R7 bit0 held at 1
    {4'd7,  2'd1, 8'hFE, 4'b0000, 8'hFF}, // R7 upper bits written
    {4'd9,  2'd3, 8'hFF, 4'b0001, 8'h00}, // R9 go, value kept 0
    {4'd8,  2'd3, 8'h0B, 4'b0000, 8'h0A}, // R8 mask 0x0A
    {4'd9,  2'd3, 8'h06, 4'b0001, 8'h0A}, // R9 go, value kept
    {4'd8,  2'd3, 8'hF1, 4'b0000, 8'h00}, // R8
    {4'd4,  2'd0, 8'h55, 4'b0010, 8'h00}, // R4
    {4'd10, 2'd2, 8'h00, 4'b0000, 8'h10}  // R10 lock survives reset request
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) rd_chk(2'(s), 8'h00, "R1");
    chk({acpi_on, acpi_off, smi_req, rst_req} == 4'b0, "R1",
        {acpi_on, acpi_off, smi_req, rst_req}, 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      logic [3:0]  fl;
      string       tag;
      v   = VECS[i];
      tag = $sformatf("R%0d vec%0d", v[25:22], i);
      wr(v[21:20], v[19:12]);
      fl = {acpi_on, acpi_off, smi_req, rst_req};
      chk(fl == v[11:8], tag, fl, v[11:8]);
      rd_chk(v[21:20], v[7:0], tag);
    end

    // pulses last one cycle only (R2, R9)
    @(negedge clk);
    chk({acpi_on, acpi_off, smi_req, rst_req} == 4'b0, "R2 R9 pulse width",
        {acpi_on, acpi_off, smi_req, rst_req}, 0);

    // R10: only power-on reset clears lock and registers
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk(2'd2, 8'h00, "R10 lock cleared");
    rd_chk(2'd1, 8'h00, "R1 smi_en");
    rd_chk(2'd3, 8'h00, "R1 rst_ctl");
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h00);
    rd_chk(2'd1, 8'h00, "R10 bit0 writable after reset");
    // R4 trigger enabled with other bits, back-to-back commands
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h00);
    chk(smi_req == 1'b1, "R4 cmd 0x00", smi_req, 1);
    wr(2'd0, 8'hF1);
    chk(smi_req == 1'b0 && acpi_on == 1'b1, "R2 after SMI", {smi_req, acpi_on}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule